// File: doc/BRIEF.md
# Timestamp-Driven Reference Tracking Loop

This block follows an external periodic reference using only the counter values at which the reference edges were captured. It never sees the reference signal itself. Each captured value is a count that wraps at a power-of-two period. The block moves that count to the top of a 32-bit word, so one counter wrap matches one full turn of a wrapping 32-bit phase.

For every accepted capture, a numerically controlled oscillator is corrected. A proportional term acts on the error between the capture and the current phase. A derivative term acts on the step from the previous capture. Both gains are arithmetic right shifts, so the loop has no multiplier. The tuning word is updated first, and the phase then advances by the new tuning word.

Captures arrive in batches. A batch holds anywhere from none up to a fixed maximum. A strobe closes each batch. On that strobe the block latches the newest phase, the tuning word, and the number of whole counter-overflow periods since the last loop update. It presents them with a one-cycle valid pulse.

Top module: `tstamp_pll`

## Requirements
- R1: While `rst` is high, and after it falls, the phase, tuning word, previous-capture word, latched outputs, overflow count and `out_valid` are all zero.
- R2: A capture of `TS_W` bits becomes a 32-bit word by a left shift of `32-TS_W`. The capture occupies bits 31 down to `32-TS_W`, and the low bits are zero.
- R3: For each accepted capture `s` (after the shift), the tuning word becomes `ftw + ((s - phase) >>> gain_p_sh) + ((s - prev) >>> gain_d_sh)`. The shifts are arithmetic, and all sums wrap modulo 2^32.
- R4: After the tuning-word update of R3, the phase becomes `phase + ftw_new`, wrapping modulo 2^32.
- R5: `prev` is the shifted value of the last accepted capture. It persists across batches and starts at zero.
- R6: At most `N_MAX` captures are accepted per batch. Further captures in the same batch change no state and do not affect the reported values.
- R7: A cycle with `batch_done` high latches the phase, tuning word and overflow count. `out_valid` is high for exactly the next cycle. Outside that, the outputs hold their values.
- R8: A capture presented in the same cycle as `batch_done` belongs to the batch that is closing. The latched values include its update.
- R9: A batch with at least one accepted capture reports a count of zero. A batch with none reports the previous count plus one.
- R10: The overflow count saturates at 2^K_W - 1 (255 by default) and does not wrap.
- R11: The gain shifts are sampled per capture, so a change takes effect from the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid | input | 1 | Capture present this cycle |
| ts_value | input | TS_W | Captured counter value |
| batch_done | input | 1 | Closes the current batch |
| gain_p_sh | input | SH_W | Right shift applied to the phase error |
| gain_d_sh | input | SH_W | Right shift applied to the capture step |
| y_out | output | 32 | Latched phase, signed |
| f_out | output | 32 | Latched tuning word, signed |
| k_out | output | K_W | Latched overflow-period count |
| out_valid | output | 1 | One-cycle strobe after `batch_done` |

## Verification
Batches of every size from empty to one above the maximum are run for a grid of proportional and derivative shifts, including zero and the widest shift. These runs separate the error term, the step term, phase-before-update ordering and the shift-only scaling. Closing a batch on the same cycle as its last capture tells the R8 ordering apart from the one-cycle-late alternative. Over-full batches show whether surplus captures leak into the state. A long run of empty batches drives the count to saturation, and a following non-empty batch clears it.

// File: rtl/tspll_pkg.sv
package tspll_pkg;

    localparam int PHASE_W = 32;

    typedef logic signed [PHASE_W-1:0] phase_t;

    typedef struct packed {
        phase_t phase;
        phase_t ftw;
        phase_t prev;
    } loop_state_t;

    typedef struct packed {
        phase_t y;
        phase_t f;
    } loop_report_t;

    function automatic phase_t shr_signed(input phase_t v, input logic [4:0] sh);
        return v >>> sh;
    endfunction

endpackage

// File: rtl/tspll_scale.sv
module tspll_scale
    import tspll_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic [TS_W-1:0] ts,
    output phase_t          word
);
    localparam int PAD_W = PHASE_W - TS_W;

    generate
        if (PAD_W == 0) begin : g_full
            assign word = phase_t'(ts);
        end else begin : g_pad
            assign word = {ts, {PAD_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/tspll_loop.sv
module tspll_loop
    import tspll_pkg::*;
#(
    parameter int SH_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  phase_t          s_word,
    input  logic [SH_W-1:0] gp_sh,
    input  logic [SH_W-1:0] gd_sh,
    output loop_report_t    report_next
);
    loop_state_t st_q, st_d;
    phase_t      err, step, ftw_new;

    always_comb begin
        err     = s_word - st_q.phase;
        step    = s_word - st_q.prev;
        ftw_new = st_q.ftw + shr_signed(err, 5'(gp_sh)) + shr_signed(step, 5'(gd_sh));
        st_d    = st_q;
        if (accept) begin
            st_d.ftw   = ftw_new;
            st_d.phase = st_q.phase + ftw_new;
            st_d.prev  = s_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign report_next.y = st_d.phase;
    assign report_next.f = st_d.ftw;
endmodule

// File: rtl/tspll_batch.sv
module tspll_batch
    import tspll_pkg::*;
#(
    parameter int N_MAX = 4,
    parameter int K_W   = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ts_valid,
    input  logic           batch_done,
    input  loop_report_t   report_next,
    output logic           accept,
    output phase_t         y_out,
    output phase_t         f_out,
    output logic [K_W-1:0] k_out,
    output logic           out_valid
);
    localparam int CNT_W = $clog2(N_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(N_MAX);
    localparam logic [K_W-1:0]   K_SAT   = {K_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [K_W-1:0]   k_q, k_d;
    logic             had_update;

    assign accept     = ts_valid && (cnt_q < CNT_LIM);
    assign had_update = (cnt_q != '0) || accept;

    always_comb begin
        if (had_update)       k_d = '0;
        else if (k_q == K_SAT) k_d = K_SAT;
        else                  k_d = k_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            k_q       <= '0;
            y_out     <= '0;
            f_out     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= batch_done;
            if (batch_done) begin
                cnt_q <= '0;
                k_q   <= k_d;
                y_out <= report_next.y;
                f_out <= report_next.f;
            end else if (accept) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign k_out = k_q;
endmodule

// File: rtl/tstamp_pll.sv
module tstamp_pll
    import tspll_pkg::*;
#(
    parameter int TS_W  = 16,
    parameter int N_MAX = 4,
    parameter int K_W   = 8,
    parameter int SH_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ts_valid,
    input  logic [TS_W-1:0]      ts_value,
    input  logic                 batch_done,
    input  logic [SH_W-1:0]      gain_p_sh,
    input  logic [SH_W-1:0]      gain_d_sh,
    output logic signed [31:0]   y_out,
    output logic signed [31:0]   f_out,
    output logic [K_W-1:0]       k_out,
    output logic                 out_valid
);
    phase_t       s_word;
    logic         accept;
    loop_report_t report_next;

    tspll_scale #(.TS_W(TS_W)) u_scale (
        .ts   (ts_value),
        .word (s_word)
    );

    tspll_loop #(.SH_W(SH_W)) u_loop (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .s_word      (s_word),
        .gp_sh       (gain_p_sh),
        .gd_sh       (gain_d_sh),
        .report_next (report_next)
    );

    tspll_batch #(.N_MAX(N_MAX), .K_W(K_W)) u_batch (
        .clk         (clk),
        .rst         (rst),
        .ts_valid    (ts_valid),
        .batch_done  (batch_done),
        .report_next (report_next),
        .accept      (accept),
        .y_out       (y_out),
        .f_out       (f_out),
        .k_out       (k_out),
        .out_valid   (out_valid)
    );
endmodule

// File: rtl/tstamp_pll_chk.sv
module tstamp_pll_chk #(
    parameter int K_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                ts_valid,
    input logic                batch_done,
    input logic signed [31:0]  y_out,
    input logic signed [31:0]  f_out,
    input logic [K_W-1:0]      k_out,
    input logic                out_valid
);
    localparam logic [K_W-1:0] ONE   = 1;
    localparam logic [K_W-1:0] K_SAT = {K_W{1'b1}};

    assert_strobe_follows_R7: assert property (@(posedge clk) disable iff (rst)
        batch_done |=> out_valid);

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        !batch_done |=> !out_valid);

    assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(y_out) && $stable(f_out) && $stable(k_out)));

    assert_same_cycle_clears_k_R8: assert property (@(posedge clk) disable iff (rst)
        (batch_done && ts_valid) |=> (k_out == '0));

    assert_k_steps_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (k_out == '0 || k_out == $past(k_out) + ONE || k_out == K_SAT));

    assert_k_saturates_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(k_out) == K_SAT) |-> (k_out == K_SAT || k_out == '0));
endmodule

bind tstamp_pll tstamp_pll_chk #(.K_W(K_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ts_valid   (ts_valid),
    .batch_done (batch_done),
    .y_out      (y_out),
    .f_out      (f_out),
    .k_out      (k_out),
    .out_valid  (out_valid)
);

// File: tb/test_tstamp_pll.sv
`timescale 1ns/1ps
module test_tstamp_pll;
    localparam int TS_W  = 16;
    localparam int N_MAX = 4;
    localparam int K_W   = 8;
    localparam int SH_W  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ts_valid = 1'b0;
    logic [TS_W-1:0] ts_value = '0;
    logic batch_done = 1'b0;
    logic [SH_W-1:0] gain_p_sh = '0;
    logic [SH_W-1:0] gain_d_sh = '0;
    logic signed [31:0] y_out, f_out;
    logic [K_W-1:0] k_out;
    logic out_valid;

    int vectors = 0;
    int errors  = 0;

    logic signed [31:0] m_phase = 0, m_ftw = 0, m_prev = 0;
    int m_k = 0;
    int m_cnt = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    tstamp_pll #(.TS_W(TS_W), .N_MAX(N_MAX), .K_W(K_W), .SH_W(SH_W)) i_tstamp_pll (
        .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_value(ts_value),
        .batch_done(batch_done), .gain_p_sh(gain_p_sh), .gain_d_sh(gain_d_sh),
        .y_out(y_out), .f_out(f_out), .k_out(k_out), .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference model of one capture (R2..R5, R11)
    task automatic model_capture(input logic [TS_W-1:0] ts);
        logic signed [31:0] s, err, stp;
        if (m_cnt < N_MAX) begin
            s     = $signed({ts, {(32-TS_W){1'b0}}});
            err   = s - m_phase;
            stp   = s - m_prev;
            m_ftw = m_ftw + (err >>> gain_p_sh) + (stp >>> gain_d_sh);
            m_phase = m_phase + m_ftw;
            m_prev  = s;
        end
        m_cnt++;
    endtask

    task automatic model_close();
        if (m_cnt > 0) m_k = 0;
        else if (m_k < 255) m_k = m_k + 1;
        m_cnt = 0;
    endtask

    function automatic logic [TS_W-1:0] next_ts();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[31:32-TS_W];
    endfunction

    // m captures; merge closes the batch on the last capture's cycle (R8)
    task automatic run_batch(input int m, input bit merge, input string req);
        for (int i = 0; i < m; i++) begin
            @(negedge clk);
            ts_valid = 1'b1;
            ts_value = next_ts();
            batch_done = (merge && i == m - 1);
            model_capture(ts_value);
        end
        if (!(merge && m > 0)) begin
            @(negedge clk);
            ts_valid = 1'b0;
            batch_done = 1'b1;
        end
        model_close();
        @(negedge clk);
        ts_valid = 1'b0;
        batch_done = 1'b0;
        check({req, " valid R7"}, 32'(out_valid), 32'd1);
        check({req, " y R3 R4"}, y_out, m_phase);
        check({req, " f R3"}, f_out, m_ftw);
        check({req, " k R9"}, 32'(k_out), 32'(m_k));
        @(negedge clk);
        check({req, " strobe width R7"}, 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("reset y R1", y_out, 32'd0);
        check("reset f R1", f_out, 32'd0);
        check("reset k R1", 32'(k_out), 32'd0);
        check("reset valid R1", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("post-reset valid R1", 32'(out_valid), 32'd0);

        // R2: gains of 31 leave ftw driven only by -1/0 sign bits; use gp=0, gd=31
        gain_p_sh = 5'd0;
        gain_d_sh = 5'd31;
        @(negedge clk);
        ts_valid = 1'b1; ts_value = 16'h0001; batch_done = 1'b1;
        model_capture(16'h0001);
        model_close();
        @(negedge clk);
        ts_valid = 1'b0; batch_done = 1'b0;
        // s = 0x00010000: ftw = s + (s>>>31 = 0); phase = ftw
        check("scale f R2", f_out, 32'h0001_0000);
        check("scale y R2", y_out, 32'h0001_0000);
        check("scale model R2", f_out, m_ftw);

        // near-exhaustive grid of gains and batch sizes (R3..R6, R8, R9, R11)
        for (int gp = 0; gp < 4; gp++) begin
            for (int gd = 0; gd < 4; gd++) begin
                gain_p_sh = (gp == 3) ? 5'd31 : 5'(gp * 3);
                gain_d_sh = (gd == 3) ? 5'd31 : 5'(gd * 2 + 1);
                for (int m = 0; m <= N_MAX + 2; m++) begin
                    run_batch(m, 1'b0, (m > N_MAX) ? "overfull R6" : "grid R3 R5 R11");
                    run_batch(m, 1'b1, "same-cycle close R8");
                end
            end
        end

        // R10: long empty run saturates, then a capture clears it
        for (int b = 0; b < 260; b++) run_batch(0, 1'b0, "empty run R10");
        check("saturated k R10", 32'(k_out), 32'd255);
        run_batch(0, 1'b0, "held at top R10");
        run_batch(1, 1'b0, "clear after sat R9");
        check("cleared k R9", 32'(k_out), 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule